// File: doc/BRIEF.md
# I2C Slave Receiver with Clock Stretching

This block is the receive side of an I2C target device. It watches SCL and SDA through synchronisers running on the system clock and recognises start and stop conditions. It shifts in a 7-bit address and the direction bit, then acknowledges when the address equals the configured value and the master is writing. Each data byte that follows goes into a one-byte receive buffer. The block then raises an end-of-byte flag so that the host can collect the byte.

The block drives the bus only through two open-drain enables: one pulls SDA low during an acknowledge slot, and one holds SCL low to make the master wait. With stretching on, the block holds SCL low at the end of a byte if the host has not emptied the buffer by the falling edge of the ninth clock. It keeps SCL low until the host sets the release bit. If a byte arrives while the buffer is still full, the byte is discarded and flagged as an overflow. That byte receives no acknowledge, and the clock is not stretched after it.

Top module: `i2c_rx_stretch`

## Requirements
- R1: After a start, the block shifts in seven address bits MSB first and then the direction bit (0 means write). If the address equals `own_addr` and the direction is 0, it pulls SDA low for the whole ninth clock as its acknowledge.
- R2: If the address differs from `own_addr`, or the direction bit is 1, the block leaves SDA high in the ninth clock. It raises no `irq` and ignores all further bytes until the next start, so `buf_full` stays 0.
- R3: In an addressed write, each data byte is shifted in MSB first. If the buffer is empty, the byte appears on `rx_data`, `buf_full` goes to 1, and the byte is acknowledged.
- R4: `irq` is set at the falling edge of the ninth clock of every byte in an addressed transfer. It stays 1 until a pulse on `irq_clr`.
- R5: A one-cycle pulse on `rd_buf` clears `buf_full`.
- R6: If a data byte completes while `buf_full` is 1, `ovf` goes to 1 and the byte is not acknowledged. `rx_data` keeps the older byte, and `ovf` stays 1 (even after a read) until a pulse on `ovf_clr`.
- R7: With `stretch_en` = 1, an acknowledged byte that leaves `buf_full` = 1 at the ninth falling edge clears `clk_rel` to 0 and asserts `scl_oe`, so SCL is held low.
- R8: If the host pulses `rd_buf` before the ninth falling edge, `clk_rel` stays 1 and SCL is not held.
- R9: SCL stays held, even if the buffer is read, until a pulse on `rel_set`. That pulse sets `clk_rel` to 1 and releases `scl_oe`.
- R10: A byte that was not acknowledged because of an overflow never causes SCL to be held, even with `stretch_en` = 1.
- R11: With `stretch_en` = 0, `scl_oe` is never asserted.
- R12: A stop condition (SDA rising while SCL is high) returns the block to idle with SDA released. The next start begins a fresh address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | 7 | Configured slave address |
| stretch_en | input | 1 | Enables clock stretching |
| rd_buf | input | 1 | Host read strobe, clears buffer-full |
| rx_data | output | 8 | Receive buffer contents |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf | output | 1 | Sticky overflow flag |
| irq_clr | input | 1 | Clears the end-of-byte flag |
| irq | output | 1 | End-of-byte flag |
| rel_set | input | 1 | Host writes clock-release bit to 1 |
| clk_rel | output | 1 | Clock-release bit (0 while stretching) |

## Verification
Some rules are checked by assertions on every cycle. An overflow never coincides with an acknowledge, and a buffer load always does. The end-of-byte pulse only ever occurs with SCL low. Whenever stretching starts, the buffer was full, stretching was enabled and the byte was acknowledged. A held clock stays held until the release strobe. The bench scenarios are needed for the rest: the actual bit order on the wire, the acknowledge levels the master sees for matching, mismatched and read-direction addresses, the contents of the buffer after an overflow, and the difference between reading the buffer before or after the ninth falling edge.

// File: rtl/i2c_rx_pkg.sv
`timescale 1ns/1ps
// Shared widths and the receive engine state type.
// Assumes a 7-bit address followed by one direction bit per address byte.
package i2c_rx_pkg;
    parameter int BYTE_W = 8;
    parameter int ADDR_W = BYTE_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer in progress
        ST_ADDR,   // shifting address and direction
        ST_DATA,   // shifting a data byte
        ST_ACK,    // inside the ninth clock
        ST_SKIP    // not addressed, wait for next start
    } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser with edge detection for a group of slow lines.
// Assumes idle-high lines (reset value 1) and STAGES >= 2.
module i2c_line_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        logic              last;

        // Shift the raw line through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], din[g]};
        end

        // Remember the previous synchronised level for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) last <= 1'b1;
            else        last <= chain[STAGES-1];
        end

        assign lvl[g]  = chain[STAGES-1];
        assign rise[g] = chain[STAGES-1] & ~last;
        assign fall[g] = ~chain[STAGES-1] & last;
    end
endmodule

// File: rtl/i2c_rx_engine.sv
`timescale 1ns/1ps
// Bit-level receive engine: start/stop detection, address match, byte
// shifting, acknowledge decision and end-of-byte event.
// Assumes synchronised, edge-detected SCL/SDA; only master-write transfers.
module i2c_rx_engine
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              buf_full,
    output logic              sda_oe,
    output logic              load,
    output logic              ovf_evt,
    output logic              byte_end,
    output logic              acked,
    output logic [BYTE_W-1:0] shreg
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

    rx_state_t        st;
    rx_state_t        after_ack;
    logic [CNT_W-1:0] cnt;
    logic             start_c;
    logic             stop_c;
    logic             addr_hit;

    assign start_c  = sda_fall & scl_lvl;
    assign stop_c   = sda_rise & scl_lvl;
    assign addr_hit = (shreg[BYTE_W-1 -: ADDR_W] == own_addr) && !shreg[0];

    // Sequence the transfer bit by bit and decide each acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            after_ack <= ST_SKIP;
            cnt       <= '0;
            shreg     <= '0;
            sda_oe    <= 1'b0;
            load      <= 1'b0;
            ovf_evt   <= 1'b0;
            byte_end  <= 1'b0;
            acked     <= 1'b0;
        end else begin
            load     <= 1'b0;
            ovf_evt  <= 1'b0;
            byte_end <= 1'b0;
            if (start_c) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                st     <= ST_IDLE;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_DATA: begin
                        if (scl_rise && cnt != LAST) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_lvl};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == LAST) begin
                            cnt <= '0;
                            st  <= ST_ACK;
                            if (st == ST_ADDR) begin
                                acked     <= addr_hit;
                                sda_oe    <= addr_hit;
                                after_ack <= addr_hit ? ST_DATA : ST_SKIP;
                            end else if (buf_full) begin
                                acked     <= 1'b0;
                                sda_oe    <= 1'b0;
                                ovf_evt   <= 1'b1;
                                after_ack <= ST_DATA;
                            end else begin
                                acked     <= 1'b1;
                                sda_oe    <= 1'b1;
                                load      <= 1'b1;
                                after_ack <= ST_DATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_oe   <= 1'b0;
                            st       <= after_ack;
                            byte_end <= (after_ack == ST_DATA);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6: an overflowed byte is never acknowledged
    a_r6_ovf_nack: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |-> !sda_oe);
    // R3: every buffer load comes with an acknowledge
    a_r3_load_acks: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> sda_oe);
    // R4: the end-of-byte event only happens with SCL low
    a_r4_end_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        byte_end |-> !scl_lvl);
    // R12: idle means SDA is released
    a_r12_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2c_rx_host.sv
`timescale 1ns/1ps
// Host-facing receive buffer and status: buffer-full, overflow, end-of-byte
// flag and clock-release bit driving the SCL hold.
// Assumes one-cycle host strobes; a set event wins over a clear in one cycle.
module i2c_rx_host
    import i2c_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              ovf_evt,
    input  logic              byte_end,
    input  logic              acked,
    input  logic              stretch_en,
    input  logic              rd_buf,
    input  logic              ovf_clr,
    input  logic              irq_clr,
    input  logic              rel_set,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    output logic              ovf,
    output logic              irq,
    output logic              clk_rel,
    output logic              scl_oe
);
    logic hold_now;

    assign hold_now = byte_end && acked && stretch_en && buf_full && !rd_buf;

    // Capture each accepted byte into the receive buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_data <= '0;
        else if (load) rx_data <= data_in;
    end

    // Track whether the buffer holds an unread byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      buf_full <= 1'b0;
        else if (load)   buf_full <= 1'b1;
        else if (rd_buf) buf_full <= 1'b0;
    end

    // Sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (ovf_evt) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    // End-of-byte flag, held until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)        irq <= 1'b0;
        else if (byte_end) irq <= 1'b1;
        else if (irq_clr)  irq <= 1'b0;
    end

    // Clock-release bit: forced low to stretch, set again by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)        clk_rel <= 1'b1;
        else if (hold_now) clk_rel <= 1'b0;
        else if (rel_set)  clk_rel <= 1'b1;
    end

    assign scl_oe = ~clk_rel;

    // R7: stretching only starts with a full buffer and stretching enabled
    a_r7_hold_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_rel) |-> ($past(buf_full) && $past(stretch_en)));
    // R10: a not-acknowledged byte never starts a stretch
    a_r10_nack_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_rel) |-> $past(acked));
    // R9: a held clock stays held until the release strobe
    a_r9_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_rel && !rel_set) |=> !clk_rel);
    // R6: overflow only clears on its own strobe
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);
endmodule

// File: rtl/i2c_rx_stretch.sv
`timescale 1ns/1ps
// Top of the I2C slave receiver: synchronises the bus lines, runs the
// receive engine and exposes the host buffer and status bits.
// Assumes an external open-drain pad: *_oe = 1 pulls the line low.
module i2c_rx_stretch
    import i2c_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              stretch_en,
    input  logic              rd_buf,
    output logic [BYTE_W-1:0] rx_data,
    output logic              buf_full,
    input  logic              ovf_clr,
    output logic              ovf,
    input  logic              irq_clr,
    output logic              irq,
    input  logic              rel_set,
    output logic              clk_rel
);
    localparam int LN_SCL = 0;
    localparam int LN_SDA = 1;

    logic [1:0]        lvl, rise, fall;
    logic              load, ovf_evt, byte_end, acked;
    logic [BYTE_W-1:0] shreg;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sda_i, scl_i}),
        .lvl  (lvl),
        .rise (rise),
        .fall (fall)
    );

    i2c_rx_engine u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (lvl[LN_SCL]),
        .scl_rise(rise[LN_SCL]),
        .scl_fall(fall[LN_SCL]),
        .sda_lvl (lvl[LN_SDA]),
        .sda_rise(rise[LN_SDA]),
        .sda_fall(fall[LN_SDA]),
        .own_addr(own_addr),
        .buf_full(buf_full),
        .sda_oe  (sda_oe),
        .load    (load),
        .ovf_evt (ovf_evt),
        .byte_end(byte_end),
        .acked   (acked),
        .shreg   (shreg)
    );

    i2c_rx_host u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .data_in   (shreg),
        .ovf_evt   (ovf_evt),
        .byte_end  (byte_end),
        .acked     (acked),
        .stretch_en(stretch_en),
        .rd_buf    (rd_buf),
        .ovf_clr   (ovf_clr),
        .irq_clr   (irq_clr),
        .rel_set   (rel_set),
        .rx_data   (rx_data),
        .buf_full  (buf_full),
        .ovf       (ovf),
        .irq       (irq),
        .clk_rel   (clk_rel),
        .scl_oe    (scl_oe)
    );

    // R11: without stretching enabled SCL is never pulled
    a_r11_no_stretch_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> $past(stretch_en));
endmodule

// File: tb/i2c_rx_stretch_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: a bus-master driver pushes the bytes it expects to be
// accepted, and a monitor pops and compares them on every buffer load.
module i2c_rx_stretch_bench;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_bus, sda_bus;
    logic scl_oe, sda_oe;
    logic [6:0] own_addr = 7'h52;
    logic stretch_en = 1'b0, rd_buf = 1'b0, ovf_clr = 1'b0, irq_clr = 1'b0, rel_set = 1'b0;
    logic [7:0] rx_data;
    logic buf_full, ovf, irq, clk_rel;

    assign scl_bus = scl_m & ~scl_oe;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_rx_stretch u_i2c_rx_stretch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr),
        .stretch_en(stretch_en), .rd_buf(rd_buf), .rx_data(rx_data),
        .buf_full(buf_full), .ovf_clr(ovf_clr), .ovf(ovf),
        .irq_clr(irq_clr), .irq(irq), .rel_set(rel_set), .clk_rel(clk_rel)
    );

    int n_cmp = 0, n_bad = 0;
    logic [7:0] exp_q[$];
    logic bf_prev = 1'b0;
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int sel);
        case (sel)
            0: rd_buf = 1'b1;
            1: irq_clr = 1'b1;
            2: ovf_clr = 1'b1;
            default: rel_set = 1'b1;
        endcase
        tick(1);
        rd_buf = 1'b0; irq_clr = 1'b0; ovf_clr = 1'b0; rel_set = 1'b0;
        tick(1);
    endtask

    task automatic scl_high;
        scl_m = 1'b1;
        tick(1);
        while (!scl_bus) tick(1);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; scl_high(); tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl_high(); tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic clk_bit(input logic b);
        sda_m = b; tick(Q);
        scl_high(); tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // Driver: send one byte; push it to the scoreboard when acceptance is expected.
    task automatic send_byte(input logic [7:0] b, input logic accept,
                             input logic rd_in_ack, output logic ack);
        if (accept) exp_q.push_back(b);
        for (int i = 7; i >= 0; i--) clk_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        if (rd_in_ack) strobe(0);
        scl_high(); tick(Q);
        ack = !sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    // Monitor: compare every new buffer load against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && buf_full && !bf_prev) begin
                if (exp_q.size() == 0) chk("R3 unexpected load", rx_data, 32'hFFFF_FFFF);
                else chk("R3 received byte", rx_data, exp_q.pop_front());
            end
            bf_prev = buf_full;
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic ack;
        tick(5); rst_n = 1'b1; tick(3);
        chk("R11 reset scl_oe", scl_oe, 0);
        chk("R12 reset sda_oe", sda_oe, 0);
        chk("R3 reset buf_full", buf_full, 0);
        chk("R6 reset ovf", ovf, 0);
        chk("R4 reset irq", irq, 0);
        chk("R9 reset clk_rel", clk_rel, 1);

        // Plain write, no stretching
        bus_start();
        send_byte({7'h52, 1'b0}, 1'b0, 1'b0, ack);
        chk("R1 address ack", ack, 1);
        chk("R4 irq after address", irq, 1);
        strobe(1);
        chk("R4 irq cleared", irq, 0);
        send_byte(8'hA5, 1'b1, 1'b0, ack);
        chk("R3 data ack", ack, 1);
        chk("R3 buf_full set", buf_full, 1);
        chk("R4 irq after data", irq, 1);
        tick(20);
        chk("R11 no hold when disabled", scl_oe, 0);
        strobe(0);
        chk("R5 read clears buf_full", buf_full, 0);
        send_byte(8'h3C, 1'b1, 1'b0, ack);
        chk("R3 second byte ack", ack, 1);
        strobe(0);
        bus_stop();
        chk("R12 sda released after stop", sda_oe, 0);
        strobe(1);

        // Mismatched address
        bus_start();
        send_byte({7'h13, 1'b0}, 1'b0, 1'b0, ack);
        chk("R2 mismatch nack", ack, 0);
        send_byte(8'hFF, 1'b0, 1'b0, ack);
        chk("R2 ignored byte nack", ack, 0);
        chk("R2 ignored buf_full", buf_full, 0);
        chk("R2 no irq", irq, 0);
        bus_stop();

        // Read direction
        bus_start();
        send_byte({7'h52, 1'b1}, 1'b0, 1'b0, ack);
        chk("R2 read direction nack", ack, 0);
        chk("R2 read direction no irq", irq, 0);
        bus_stop();

        // Overflow without stretching
        bus_start();
        send_byte({7'h52, 1'b0}, 1'b0, 1'b0, ack);
        send_byte(8'h81, 1'b1, 1'b0, ack);
        send_byte(8'h7E, 1'b0, 1'b0, ack);
        chk("R6 overflow nack", ack, 0);
        chk("R6 ovf set", ovf, 1);
        chk("R6 buffer kept", rx_data, 8'h81);
        chk("R11 no hold on overflow", scl_oe, 0);
        strobe(0);
        chk("R6 ovf sticky after read", ovf, 1);
        strobe(2);
        chk("R6 ovf cleared", ovf, 0);
        bus_stop();
        strobe(1);

        // Stretching: unread buffer holds SCL
        stretch_en = 1'b1;
        bus_start();
        send_byte({7'h52, 1'b0}, 1'b0, 1'b0, ack);
        chk("R8 empty buffer no hold after address", scl_oe, 0);
        send_byte(8'h96, 1'b1, 1'b0, ack);
        tick(20);
        chk("R7 scl held", scl_oe, 1);
        chk("R7 clk_rel cleared", clk_rel, 0);
        strobe(0);
        tick(20);
        chk("R9 read alone keeps hold", scl_oe, 1);
        strobe(3);
        chk("R9 release drops hold", scl_oe, 0);
        chk("R9 clk_rel set", clk_rel, 1);

        // Read inside the ninth clock: no stretch
        send_byte(8'h5A, 1'b1, 1'b1, ack);
        tick(20);
        chk("R8 early read no hold", scl_oe, 0);
        chk("R8 clk_rel kept", clk_rel, 1);

        // Overflow with stretching enabled
        send_byte(8'hC3, 1'b1, 1'b0, ack);
        tick(5);
        chk("R7 held again", scl_oe, 1);
        strobe(3);
        send_byte(8'h24, 1'b0, 1'b0, ack);
        chk("R10 overflow nack", ack, 0);
        tick(20);
        chk("R10 no hold after nack", scl_oe, 0);
        chk("R6 ovf with stretching", ovf, 1);
        chk("R6 buffer kept with stretching", rx_data, 8'hC3);
        strobe(0);
        strobe(2);
        bus_stop();

        // New transfer after stop
        bus_start();
        send_byte({7'h52, 1'b0}, 1'b0, 1'b0, ack);
        chk("R12 fresh address ack", ack, 1);
        send_byte(8'h11, 1'b1, 1'b1, ack);
        chk("R12 fresh data ack", ack, 1);
        bus_stop();
        tick(10);
        chk("R3 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule